// File: doc/BRIEF.md
# Fractional-N Rate Setting Calculator

This block turns a requested synthesizer output frequency into the settings a fractional-N loop needs. It takes a reference frequency and a requested frequency. It returns four things: the integer multiplier, a 32-bit fractional multiplier rounded upward, the 40-bit value a fraction register would hold, and the output rate those settings actually produce. The achieved rate is then compared against a parameter table of four oscillator ranges. The block picks the band code of the first range that fits, or, when none fits, raises a flag and reports the rate clamped to the table's limits.

A caller applies both frequencies and pulses `start_i`. A shared restoring divider produces one quotient bit per clock, first for the integer part and then for the fraction. A final cycle forms the achieved rate and the band result. `done_o` then pulses for one cycle, and from that cycle on every result output is valid. The block also packs the band code and a fraction-enable flag into a 32-bit control word, ready for a control register.

Top module: `rfc_rate_calc`

## Requirements
- R1: `int_mult_o` is floor(req / ref), and `rate_o` is the low 32 bits of ref × int_mult + ((ref × frac_mult) >> 32).
- R2: When req is an exact multiple of ref, `frac_mult_o` is 0 and `rate_o` equals req.
- R3: Otherwise `frac_mult_o` is ceil(((req mod ref) << 32) / ref): one more than the truncated quotient whenever that division leaves a remainder.
- R4: `frac_reg_o` is 40 bits wide and equals `frac_mult_o` shifted left by 8, so its low 8 bits are zero.
- R5: The band is the lowest-indexed of four table entries whose inclusive [min, max] range holds `rate_o`, and `band_o` is that entry's 2-bit code. The defaults are 0: 500–1000 MHz, 1: 750–1500 MHz, 2: 1500–2000 MHz, 3: 2000–3000 MHz, each with code equal to its index.
- R6: When no entry holds the rate, `no_band_o` is 1, `band_o` is 0, and `clamp_rate_o` is entry 0's min if the rate is below it and entry 3's max otherwise. When a band matches, `clamp_rate_o` equals `rate_o` and `no_band_o` is 0.
- R7: `user_ctl_o` has bit 24 (fraction enable) set and bits 21:20 equal to `band_o` when a band matches, with every other bit zero. It is all zero when no band matches.
- R8: `busy_o` is high from the cycle after `start_i` is accepted in idle until the result cycle. `done_o` is a single-cycle pulse on the 66th rising edge counted from the accepting edge (that edge itself is the first), with `busy_o` low in that cycle.
- R9: Operands are captured on the accepting edge. `start_i` and operand changes while busy have no effect on that calculation's results.
- R10: A zero reference gives zero `int_mult_o`, `frac_mult_o` and `rate_o`, and the no-band handling of R6.
- R11: After reset every output is zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted while idle |
| ref_freq_i | input | 32 | Reference frequency |
| req_freq_i | input | 32 | Requested output frequency |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result pulse |
| int_mult_o | output | 32 | Integer multiplier |
| frac_mult_o | output | 32 | Fractional multiplier (ceiling) |
| frac_reg_o | output | 40 | Fraction register value |
| rate_o | output | 32 | Achieved output rate |
| band_o | output | 2 | Selected band code |
| no_band_o | output | 1 | No table range holds the rate |
| clamp_rate_o | output | 32 | Rate clamped to the table limits |
| user_ctl_o | output | 32 | Packed control word |

## Verification
The bench targets overlapping ranges and range endpoints. A matcher that picked the last match, or used exclusive bounds, would report code 1 instead of 0 at 900 MHz, or miss 1500 MHz and 3000 MHz. It also runs exact multiples and non-dividing ratios. A design that truncated the fraction would be one low on the fraction, and a stale remainder would leave a nonzero fraction where none belongs. Other cases cover rates below and above the whole table, a zero reference, a reference above the request, and a restart attempt in mid-run. These catch a wrong clamp direction, a divide-by-zero value leaking out, and operands sampled late.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
    parameter int RFC_FW   = 32;
    parameter int RFC_BW   = 2;
    parameter int RFC_CW   = $clog2(RFC_FW);

    typedef enum logic [1:0] {ST_IDLE, ST_DIVI, ST_DIVF, ST_FIN} rfc_state_e;

    typedef struct packed {
        rfc_state_e         st;
        logic [RFC_CW-1:0]  cnt;
        logic [RFC_FW-1:0]  ref_v;
        logic [RFC_FW-1:0]  rem;
        logic [RFC_FW-1:0]  dvd;
        logic [RFC_FW-1:0]  lmul;
        logic [RFC_FW-1:0]  amul;
        logic [RFC_FW-1:0]  rate;
        logic [RFC_FW-1:0]  clamp;
        logic [RFC_BW-1:0]  band;
        logic               nob;
        logic [31:0]        ctl;
        logic               done;
    } rfc_regs_t;
endpackage

// File: rtl/rfc_div_step.sv
module rfc_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] dvsr_i,
    output logic [W-1:0] rem_o,
    output logic         q_o
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        shifted = {rem_i, bit_i};
        trial   = shifted - {1'b0, dvsr_i};
        q_o     = ~trial[W];
        rem_o   = q_o ? trial[W-1:0] : shifted[W-1:0];
    end
endmodule

// File: rtl/rfc_band_sel.sv
module rfc_band_sel #(
    parameter int N  = 4,
    parameter int W  = 32,
    parameter int BW = 2,
    parameter logic [N-1:0][W-1:0]  LO   = '0,
    parameter logic [N-1:0][W-1:0]  HI   = '0,
    parameter logic [N-1:0][BW-1:0] CODE = '0
) (
    input  logic [W-1:0]  rate_i,
    output logic          hit_o,
    output logic [BW-1:0] code_o,
    output logic [W-1:0]  clamp_o
);
    logic [N-1:0] in_rng;

    for (genvar g = 0; g < N; g++) begin : g_rng
        assign in_rng[g] = (rate_i >= LO[g]) && (rate_i <= HI[g]);
    end

    always_comb begin
        hit_o  = 1'b0;
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (in_rng[i]) begin
                hit_o  = 1'b1;
                code_o = CODE[i];
            end
        end
        if (hit_o)               clamp_o = rate_i;
        else if (rate_i < LO[0]) clamp_o = LO[0];
        else                     clamp_o = HI[N-1];
    end
endmodule

// File: rtl/rfc_rate_calc.sv
module rfc_rate_calc
    import rfc_pkg::*;
#(
    parameter int FRAC_PAD = 8,
    parameter int NB       = 4,
    parameter int CTL_EN_BIT   = 24,
    parameter int CTL_BAND_LSB = 20,
    parameter logic [NB-1:0][RFC_FW-1:0] VCO_LO =
        {32'd2000000000, 32'd1500000000, 32'd750000000, 32'd500000000},
    parameter logic [NB-1:0][RFC_FW-1:0] VCO_HI =
        {32'd3000000000, 32'd2000000000, 32'd1500000000, 32'd1000000000},
    parameter logic [NB-1:0][RFC_BW-1:0] VCO_CODE = {2'd3, 2'd2, 2'd1, 2'd0}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [RFC_FW-1:0]            ref_freq_i,
    input  logic [RFC_FW-1:0]            req_freq_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [RFC_FW-1:0]            int_mult_o,
    output logic [RFC_FW-1:0]            frac_mult_o,
    output logic [RFC_FW+FRAC_PAD-1:0]   frac_reg_o,
    output logic [RFC_FW-1:0]            rate_o,
    output logic [RFC_BW-1:0]            band_o,
    output logic                         no_band_o,
    output logic [RFC_FW-1:0]            clamp_rate_o,
    output logic [31:0]                  user_ctl_o
);
    localparam logic [RFC_CW-1:0] LAST = RFC_CW'(RFC_FW - 1);

    rfc_regs_t r_q, r_d;

    logic [RFC_FW-1:0] step_rem;
    logic              step_q;
    logic              step_bit;
    logic [RFC_FW-1:0] alpha_c;
    logic [RFC_FW-1:0] frac_hi_c;
    logic [RFC_FW-1:0] rate_c;
    logic              hit_c;
    logic [RFC_BW-1:0] code_c;
    logic [RFC_FW-1:0] clamp_c;

    assign step_bit = (r_q.st == ST_DIVI) ? r_q.dvd[RFC_FW-1] : 1'b0;

    rfc_div_step #(.W(RFC_FW)) u_step (
        .rem_i (r_q.rem),
        .bit_i (step_bit),
        .dvsr_i(r_q.ref_v),
        .rem_o (step_rem),
        .q_o   (step_q)
    );

    // Result-cycle arithmetic: ceiling fraction and achieved rate.
    always_comb begin
        alpha_c   = r_q.dvd + {{(RFC_FW-1){1'b0}}, (|r_q.rem)};
        frac_hi_c = RFC_FW'(({{RFC_FW{1'b0}}, r_q.ref_v} * {{RFC_FW{1'b0}}, alpha_c}) >> RFC_FW);
        rate_c    = RFC_FW'(r_q.ref_v * r_q.lmul) + frac_hi_c;
        if (r_q.ref_v == '0) begin
            alpha_c = '0;
            rate_c  = '0;
        end
    end

    rfc_band_sel #(
        .N(NB), .W(RFC_FW), .BW(RFC_BW),
        .LO(VCO_LO), .HI(VCO_HI), .CODE(VCO_CODE)
    ) u_band (
        .rate_i (rate_c),
        .hit_o  (hit_c),
        .code_o (code_c),
        .clamp_o(clamp_c)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_DIVI;
                    r_d.cnt   = '0;
                    r_d.ref_v = ref_freq_i;
                    r_d.dvd   = req_freq_i;
                    r_d.rem   = '0;
                end
            end
            ST_DIVI: begin
                r_d.rem = step_rem;
                r_d.dvd = {r_q.dvd[RFC_FW-2:0], step_q};
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st   = ST_DIVF;
                    r_d.lmul = {r_q.dvd[RFC_FW-2:0], step_q};
                    r_d.dvd  = '0;
                    r_d.cnt  = '0;
                end
            end
            ST_DIVF: begin
                r_d.rem = step_rem;
                r_d.dvd = {r_q.dvd[RFC_FW-2:0], step_q};
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) r_d.st = ST_FIN;
            end
            ST_FIN: begin
                r_d.st    = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.lmul  = (r_q.ref_v == '0) ? '0 : r_q.lmul;
                r_d.amul  = alpha_c;
                r_d.rate  = rate_c;
                r_d.nob   = ~hit_c;
                r_d.band  = code_c;
                r_d.clamp = clamp_c;
                r_d.ctl   = '0;
                if (hit_c) begin
                    r_d.ctl[CTL_EN_BIT] = 1'b1;
                    r_d.ctl[CTL_BAND_LSB +: RFC_BW] = code_c;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign int_mult_o   = r_q.lmul;
    assign frac_mult_o  = r_q.amul;
    assign frac_reg_o   = {r_q.amul, {FRAC_PAD{1'b0}}};
    assign rate_o       = r_q.rate;
    assign band_o       = r_q.band;
    assign no_band_o    = r_q.nob;
    assign clamp_rate_o = r_q.clamp;
    assign user_ctl_o   = r_q.ctl;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o) && !busy_o);

    assert_operands_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(r_q.ref_v));

    assert_clamp_limits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && no_band_o) |-> (clamp_rate_o == VCO_LO[0] || clamp_rate_o == VCO_HI[NB-1]));

    assert_ctl_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !no_band_o) |-> (user_ctl_o[CTL_EN_BIT] &&
            user_ctl_o[CTL_BAND_LSB +: RFC_BW] == band_o && clamp_rate_o == rate_o));
endmodule

// File: tb/rfc_rate_calc_tb.sv
module rfc_rate_calc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ref_freq_i = '0;
    logic [31:0] req_freq_i = '0;
    logic        busy_o, done_o, no_band_o;
    logic [31:0] int_mult_o, frac_mult_o, rate_o, clamp_rate_o, user_ctl_o;
    logic [39:0] frac_reg_o;
    logic [1:0]  band_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rfc_rate_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ref_freq_i(ref_freq_i), .req_freq_i(req_freq_i),
        .busy_o(busy_o), .done_o(done_o), .int_mult_o(int_mult_o),
        .frac_mult_o(frac_mult_o), .frac_reg_o(frac_reg_o), .rate_o(rate_o),
        .band_o(band_o), .no_band_o(no_band_o), .clamp_rate_o(clamp_rate_o),
        .user_ctl_o(user_ctl_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference built from the requirement text.
    task automatic run_case(input logic [31:0] rf, input logic [31:0] rq, input bit poke);
        logic [63:0] l, r, a, rate, clamp;
        logic [31:0] lo [4];
        logic [31:0] hi [4];
        logic [1:0]  code;
        logic [31:0] ctl;
        bit hit;
        bit seq_ok;
        lo = '{32'd500000000, 32'd750000000, 32'd1500000000, 32'd2000000000};
        hi = '{32'd1000000000, 32'd1500000000, 32'd2000000000, 32'd3000000000};
        if (rf == 0) begin
            l = 0; a = 0; rate = 0;
        end else begin
            l = rq / rf;
            r = rq % rf;
            a = (r == 0) ? 64'd0 : (((r << 32) + {32'd0, rf} - 64'd1) / rf);
            rate = ((rf * l) + ((rf * a) >> 32)) & 64'hFFFF_FFFF;
        end
        hit = 0; code = 0;
        for (int i = 3; i >= 0; i--)
            if (rate >= lo[i] && rate <= hi[i]) begin hit = 1; code = 2'(i); end
        clamp = hit ? rate : (rate < lo[0] ? {32'd0, lo[0]} : {32'd0, hi[3]});
        ctl = hit ? ((32'd1 << 24) | ({30'd0, code} << 20)) : 32'd0;

        @(negedge clk);
        start_i = 1'b1; ref_freq_i = rf; req_freq_i = rq;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0; ref_freq_i = 32'h1234_5678; req_freq_i = 32'hDEAD_BEEF;
        seq_ok = 1;
        for (int i = 0; i < 65; i++) begin
            if (poke) start_i = (i == 3);
            if (busy_o !== 1'b1 || done_o !== 1'b0) seq_ok = 0;
            @(posedge clk); @(negedge clk);
        end
        start_i = 1'b0;
        check("R8 busy held low-done during run", {63'd0, seq_ok}, 64'd1);
        check("R8 done pulse", {62'd0, done_o, busy_o}, 64'd2);
        check("R1 int_mult", {32'd0, int_mult_o}, l);
        check("R3 frac_mult ceiling", {32'd0, frac_mult_o}, a);
        check("R4 frac_reg", {24'd0, frac_reg_o}, a << 8);
        check("R1 rate", {32'd0, rate_o}, rate);
        check("R5 band", {62'd0, band_o}, {62'd0, code});
        check("R6 no_band", {63'd0, no_band_o}, {63'd0, !hit});
        check("R6 clamp", {32'd0, clamp_rate_o}, clamp);
        check("R7 user_ctl", {32'd0, user_ctl_o}, {32'd0, ctl});
        @(posedge clk); @(negedge clk);
        check("R8 done single cycle", {63'd0, done_o}, 64'd0);
    endtask

    initial begin
        #30000000;
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset busy/done", {62'd0, busy_o, done_o}, 64'd0);
        check("R11 reset outputs", {32'd0, int_mult_o | frac_mult_o | rate_o | clamp_rate_o | user_ctl_o}, 64'd0);
        check("R11 reset band", {61'd0, no_band_o, band_o}, 64'd0);
        rst_n = 1'b1;
        run_case(32'd19200000, 32'd600000000, 0);   // R3 fractional, band 0
        run_case(32'd25000000, 32'd800000000, 0);   // R2 exact multiple
        run_case(32'd19200000, 32'd1000000001, 0);  // R3 rounding up
        run_case(32'd27000000, 32'd900000000, 0);   // R5 overlap picks entry 0
        run_case(32'd30000000, 32'd1500000000, 0);  // R5 inclusive max of entry 1
        run_case(32'd30000000, 32'd3000000000, 0);  // R5 inclusive max of last entry
        run_case(32'd19200000, 32'd100000000, 0);   // R6 below table
        run_case(32'd19200000, 32'd3500000000, 0);  // R6 above table
        run_case(32'd0, 32'd900000000, 0);          // R10 zero reference
        run_case(32'd3000000000, 32'd2000000000, 0);// R1 integer part zero
        run_case(32'd1, 32'hFFFF_FFFF, 0);          // R1 largest quotient
        run_case(32'd38400000, 32'd1766400007, 1);  // R9 restart attempt ignored
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule